// File: doc/BRIEF.md
# Modular-Exponentiation Accelerator Control Front-End

This block sits between a CPU register bus and a modular-exponentiation arithmetic core. Software programs a source address in system memory, a transfer length in bytes, and the bit counts of the exponent and the modulus. A command register decides who owns the operand SRAM. When the command register hands the SRAM to the engine in operand-fetch mode, one write to the trigger register launches a word-by-word fetch from memory into the SRAM. The same write can also launch the arithmetic core. The compute start is held back until the fetch has stored its last word.

When the core reports completion, a sticky status flag is set. A CPU write of one clears that flag. The flag drives the interrupt output through a mask bit. A busy flag shows that a job is in flight, and trigger writes made during that time have no effect. When the CPU owns the SRAM, it can read and write the operands directly through an address window. While the engine owns the SRAM, that window reads as zero and ignores writes.

Top module: `modexp_ctrl`

## Requirements
- R1: After reset the trigger register (0x000), the mask register (0x3F8) and the status register (0x3FC) read 0, the command register (0x048) reads 0x100, and irq is low.
- R2: The source base (0x04C), the length (0x050) and the key-length register (0x058) read back as written. Key-length bits [31:16] appear on core_exp_bits and bits [15:0] on core_mod_bits. The mask register keeps only bit 1.
- R3: The SRAM window starts at bus address 0x2000, one 32-bit word per 4 bytes. When command bit 8 is 1, the CPU reads and writes it. When command bit 8 is 0, reads return 0 and writes are dropped.
- R4: A trigger with bit 1 set, while the command register has bits [5:4]=3 and bit 8=0, issues one memory word read at a time. The reads start at the base with its low two bits cleared and advance by 4. Each word is stored at SRAM word 0, 1, 2 and so on, in order.
- R5: The number of words fetched is the length divided by 4, rounded up, and limited to the SRAM depth (1536 words by default). A length of 0 issues no read.
- R6: If the command register is not in fetch mode (bits [5:4] not 3, or bit 8 set), trigger bit 1 issues no memory read.
- R7: Trigger bit 0 produces exactly one single-cycle core_start. When bit 1 also starts a fetch, core_start comes only after every fetched word has been stored.
- R8: A core_done received while waiting on the core sets status bit 1. Writing 1 to that bit clears it, and writing 0 leaves it set.
- R9: irq is high exactly when status bit 1 and mask bit 1 are both 1.
- R10: Status bit 0 is 1 from an accepted trigger until the job ends. A trigger written while that bit is 1 changes nothing: the trigger readback stays the same, and no extra reads or starts occur.
- R11: The trigger register reads back the last accepted value in bits [1:0]. Writing 0 while idle clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | BUS_AW | Byte address; top bit selects the SRAM window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| mem_rd_req | output | 1 | One-cycle memory read request |
| mem_rd_addr | output | 32 | Word-aligned read address |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | 32 | Returned word |
| core_start | output | 1 | One-cycle start to the arithmetic core |
| core_done | input | 1 | Completion from the arithmetic core |
| core_exp_bits | output | 16 | Exponent bit count |
| core_mod_bits | output | 16 | Modulus bit count |
| irq | output | 1 | Masked completion interrupt |

## Verification
The bench builds the block with its defaults: a 14-bit bus address and an SRAM of 1536 words. With those values, a directed job whose length goes past the SRAM size can show the limit on the word count. That job ends at the last SRAM word, and a sentinel word written just beyond a short fetch shows that nothing past the count is touched. The bench's memory model answers with a two-cycle latency and its core model with a ten-cycle latency. Those delays keep the busy window long enough to test trigger writes made during a job.

// File: rtl/modexp_ctrl_pkg.sv
package modexp_ctrl_pkg;

  localparam logic [11:0] OFS_TRIG = 12'h000;
  localparam logic [11:0] OFS_CMD  = 12'h048;
  localparam logic [11:0] OFS_BASE = 12'h04C;
  localparam logic [11:0] OFS_LEN  = 12'h050;
  localparam logic [11:0] OFS_KEY  = 12'h058;
  localparam logic [11:0] OFS_MASK = 12'h3F8;
  localparam logic [11:0] OFS_STS  = 12'h3FC;

  typedef enum logic [1:0] {
    JOB_IDLE,
    JOB_FETCH,
    JOB_START,
    JOB_WAIT
  } job_state_e;

  typedef enum logic [1:0] {
    FT_IDLE,
    FT_REQ,
    FT_WAIT,
    FT_FIN
  } fetch_state_e;

  // Words to fetch for a byte length: rounded up, limited to the SRAM depth.
  function automatic logic [31:0] fetch_words(input logic [31:0] len_bytes,
                                              input int unsigned depth);
    logic [32:0] w;
    w = ({1'b0, len_bytes} + 33'd3) >> 2;
    if (w > 33'(depth)) return 32'(depth);
    return w[31:0];
  endfunction

endpackage

// File: rtl/modexp_ctrl_regs.sv
module modexp_ctrl_regs
  import modexp_ctrl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en_i,
  input  logic [11:0] addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        busy_i,
  input  logic        done_evt_i,
  output logic        trig_go_o,
  output logic [1:0]  trig_go_bits_o,
  output logic        trig_compute_o,
  output logic        cpu_owns_o,
  output logic        fetch_mode_o,
  output logic [31:0] base_o,
  output logic [31:0] len_o,
  output logic [31:0] key_o,
  output logic        irq_o
);

  logic [1:0]  trig_q;
  logic        cmd_cpu_q;
  logic [1:0]  cmd_mode_q;
  logic [31:0] base_q, len_q, key_q;
  logic        mask_q;
  logic        sts_done_q;

  logic trig_wr, sts_w1c;
  assign trig_wr = wr_en_i && (addr_i == OFS_TRIG);
  assign sts_w1c = wr_en_i && (addr_i == OFS_STS) && wdata_i[1];

  assign trig_go_o      = trig_wr && !busy_i && (wdata_i[1:0] != 2'b00);
  assign trig_go_bits_o = wdata_i[1:0];
  assign trig_compute_o = trig_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q     <= 2'b00;
      cmd_cpu_q  <= 1'b1;
      cmd_mode_q <= 2'b00;
      base_q     <= '0;
      len_q      <= '0;
      key_q      <= '0;
      mask_q     <= 1'b0;
    end else if (wr_en_i) begin
      case (addr_i)
        OFS_TRIG: if (!busy_i) trig_q <= wdata_i[1:0];
        OFS_CMD: begin
          cmd_cpu_q  <= wdata_i[8];
          cmd_mode_q <= wdata_i[5:4];
        end
        OFS_BASE: base_q <= wdata_i;
        OFS_LEN:  len_q  <= wdata_i;
        OFS_KEY:  key_q  <= wdata_i;
        OFS_MASK: mask_q <= wdata_i[1];
        default: ;
      endcase
    end
  end

  // Completion flag: a new completion wins over a simultaneous clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sts_done_q <= 1'b0;
    else if (done_evt_i) sts_done_q <= 1'b1;
    else if (sts_w1c)    sts_done_q <= 1'b0;
  end

  assign cpu_owns_o   = cmd_cpu_q;
  assign fetch_mode_o = (cmd_mode_q == 2'b11) && !cmd_cpu_q;
  assign base_o       = base_q;
  assign len_o        = len_q;
  assign key_o        = key_q;
  assign irq_o        = sts_done_q && mask_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_TRIG: rdata_o = {30'd0, trig_q};
      OFS_CMD:  rdata_o = {23'd0, cmd_cpu_q, 2'b00, cmd_mode_q, 4'd0};
      OFS_BASE: rdata_o = base_q;
      OFS_LEN:  rdata_o = len_q;
      OFS_KEY:  rdata_o = key_q;
      OFS_MASK: rdata_o = {30'd0, mask_q, 1'b0};
      OFS_STS:  rdata_o = {30'd0, sts_done_q, busy_i};
      default:  rdata_o = '0;
    endcase
  end

  p_done_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt_i |=> sts_done_q);
  p_clear_by_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sts_done_q) |-> $past(sts_w1c));
  p_trig_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && $past(busy_i)) |-> $stable(trig_q));

endmodule

// File: rtl/modexp_ctrl_dma.sv
module modexp_ctrl_dma
  import modexp_ctrl_pkg::*;
#(
  parameter int unsigned SRAM_WORDS = 1536,
  localparam int unsigned CNT_W = $clog2(SRAM_WORDS + 1),
  localparam int unsigned SIDX_W = $clog2(SRAM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic [31:0]       base_i,
  input  logic [31:0]       len_i,
  output logic              mem_rd_req_o,
  output logic [31:0]       mem_rd_addr_o,
  input  logic              mem_rd_valid_i,
  input  logic [31:0]       mem_rd_data_i,
  output logic              wr_en_o,
  output logic [SIDX_W-1:0] wr_idx_o,
  output logic [31:0]       wr_data_o,
  output logic              done_o,
  output logic              busy_o
);

  fetch_state_e     st_q;
  logic [CNT_W-1:0] idx_q, total_q;
  logic [31:0]      addr_q;
  logic [31:0]      words;

  assign words = fetch_words(len_i, SRAM_WORDS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= FT_IDLE;
      idx_q   <= '0;
      total_q <= '0;
      addr_q  <= '0;
    end else begin
      case (st_q)
        FT_IDLE: if (go_i) begin
          idx_q   <= '0;
          total_q <= CNT_W'(words);
          addr_q  <= {base_i[31:2], 2'b00};
          st_q    <= (words == 32'd0) ? FT_FIN : FT_REQ;
        end
        FT_REQ: st_q <= FT_WAIT;
        FT_WAIT: if (mem_rd_valid_i) begin
          idx_q  <= idx_q + 1'b1;
          addr_q <= addr_q + 32'd4;
          st_q   <= (idx_q + 1'b1 == total_q) ? FT_FIN : FT_REQ;
        end
        FT_FIN: st_q <= FT_IDLE;
        default: st_q <= FT_IDLE;
      endcase
    end
  end

  assign mem_rd_req_o  = (st_q == FT_REQ);
  assign mem_rd_addr_o = addr_q;
  assign wr_en_o       = (st_q == FT_WAIT) && mem_rd_valid_i;
  assign wr_idx_o      = idx_q[SIDX_W-1:0];
  assign wr_data_o     = mem_rd_data_i;
  assign done_o        = (st_q == FT_FIN);
  assign busy_o        = (st_q != FT_IDLE);

  p_write_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (idx_q < total_q));
  p_one_outstanding_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req_o |=> !mem_rd_req_o);

endmodule

// File: rtl/modexp_ctrl_opram.sv
module modexp_ctrl_opram #(
  parameter int unsigned WORDS = 1536,
  parameter int unsigned CPU_IW = 11,
  localparam int unsigned SIDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              cpu_owns_i,
  input  logic              cpu_we_i,
  input  logic [CPU_IW-1:0] cpu_idx_i,
  input  logic [31:0]       cpu_wdata_i,
  output logic [31:0]       cpu_rdata_o,
  input  logic              dma_we_i,
  input  logic [SIDX_W-1:0] dma_idx_i,
  input  logic [31:0]       dma_wdata_i
);

  logic [31:0] mem [WORDS];
  logic        cpu_in_range;
  logic        cpu_ok;

  assign cpu_in_range = 32'(cpu_idx_i) < 32'(WORDS);
  assign cpu_ok       = cpu_owns_i && cpu_in_range;

  always_ff @(posedge clk) begin
    if (dma_we_i && !cpu_owns_i) mem[dma_idx_i] <= dma_wdata_i;
    else if (cpu_we_i && cpu_ok)  mem[cpu_idx_i[SIDX_W-1:0]] <= cpu_wdata_i;
  end

  assign cpu_rdata_o = cpu_ok ? mem[cpu_idx_i[SIDX_W-1:0]] : 32'd0;

endmodule

// File: rtl/modexp_ctrl.sv
module modexp_ctrl
  import modexp_ctrl_pkg::*;
#(
  parameter int unsigned BUS_AW = 14,
  parameter int unsigned SRAM_WORDS = 1536
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mem_rd_req,
  output logic [31:0]       mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [31:0]       mem_rd_data,
  output logic              core_start,
  input  logic              core_done,
  output logic [15:0]       core_exp_bits,
  output logic [15:0]       core_mod_bits,
  output logic              irq
);

  localparam int unsigned WIN_IW = BUS_AW - 3;
  localparam int unsigned SIDX_W = $clog2(SRAM_WORDS);

  job_state_e  st_q;
  logic        win_sel;
  logic        reg_wr;
  logic [31:0] reg_rdata, ram_rdata;
  logic        busy, done_evt;
  logic        trig_go, trig_compute;
  logic [1:0]  go_bits;
  logic        cpu_owns, fetch_mode;
  logic [31:0] base, len, key;
  logic        dma_go, dma_done, dma_busy;
  logic        dma_we;
  logic [SIDX_W-1:0] dma_idx;
  logic [31:0] dma_wdata;

  assign win_sel = bus_addr[BUS_AW-1];
  assign reg_wr  = bus_sel && bus_we && !win_sel;

  assign busy     = (st_q != JOB_IDLE);
  assign done_evt = (st_q == JOB_WAIT) && core_done;
  assign dma_go   = trig_go && go_bits[1] && fetch_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= JOB_IDLE;
    else begin
      case (st_q)
        JOB_IDLE: if (trig_go) begin
          if (go_bits[1] && fetch_mode) st_q <= JOB_FETCH;
          else if (go_bits[0])          st_q <= JOB_START;
        end
        JOB_FETCH: if (dma_done) st_q <= trig_compute ? JOB_START : JOB_IDLE;
        JOB_START: st_q <= JOB_WAIT;
        JOB_WAIT:  if (core_done) st_q <= JOB_IDLE;
        default:   st_q <= JOB_IDLE;
      endcase
    end
  end

  assign core_start    = (st_q == JOB_START);
  assign core_exp_bits = key[31:16];
  assign core_mod_bits = key[15:0];
  assign bus_rdata     = win_sel ? ram_rdata : reg_rdata;

  modexp_ctrl_regs u_regs (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en_i        (reg_wr),
    .addr_i         (bus_addr[11:0]),
    .wdata_i        (bus_wdata),
    .rdata_o        (reg_rdata),
    .busy_i         (busy),
    .done_evt_i     (done_evt),
    .trig_go_o      (trig_go),
    .trig_go_bits_o (go_bits),
    .trig_compute_o (trig_compute),
    .cpu_owns_o     (cpu_owns),
    .fetch_mode_o   (fetch_mode),
    .base_o         (base),
    .len_o          (len),
    .key_o          (key),
    .irq_o          (irq)
  );

  modexp_ctrl_dma #(.SRAM_WORDS(SRAM_WORDS)) u_dma (
    .clk            (clk),
    .rst_n          (rst_n),
    .go_i           (dma_go),
    .base_i         (base),
    .len_i          (len),
    .mem_rd_req_o   (mem_rd_req),
    .mem_rd_addr_o  (mem_rd_addr),
    .mem_rd_valid_i (mem_rd_valid),
    .mem_rd_data_i  (mem_rd_data),
    .wr_en_o        (dma_we),
    .wr_idx_o       (dma_idx),
    .wr_data_o      (dma_wdata),
    .done_o         (dma_done),
    .busy_o         (dma_busy)
  );

  modexp_ctrl_opram #(.WORDS(SRAM_WORDS), .CPU_IW(WIN_IW)) u_ram (
    .clk         (clk),
    .cpu_owns_i  (cpu_owns),
    .cpu_we_i    (bus_sel && bus_we && win_sel),
    .cpu_idx_i   (bus_addr[BUS_AW-2:2]),
    .cpu_wdata_i (bus_wdata),
    .cpu_rdata_o (ram_rdata),
    .dma_we_i    (dma_we),
    .dma_idx_i   (dma_idx),
    .dma_wdata_i (dma_wdata)
  );

  p_start_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start);
  p_start_after_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> !dma_busy);
  p_busy_until_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == JOB_WAIT) && !core_done) |=> busy);
  p_no_read_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> (st_q == JOB_FETCH));

endmodule

// File: tb/modexp_ctrl_tb_top.sv
module modexp_ctrl_tb_top;

  localparam int unsigned DEPTH = 1536;
  localparam int unsigned MEM_LAT = 2;
  localparam int unsigned CORE_LAT = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [13:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic        core_start;
  logic        core_done = 1'b0;
  logic [15:0] core_exp_bits, core_mod_bits;
  logic        irq;

  int n_checks = 0, n_fail = 0;
  int reads = 0, starts = 0, exp_words_now = 0;
  logic [31:0] next_addr = '0;
  bit finished = 0;

  always #5 clk = ~clk;

  modexp_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .core_start(core_start), .core_done(core_done),
    .core_exp_bits(core_exp_bits), .core_mod_bits(core_mod_bits), .irq(irq)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h5A5A_1234;
  endfunction

  function automatic int exp_words(input logic [31:0] len);
    longint w;
    w = longint'(len / 4) + ((len % 4) != 0 ? 1 : 0);
    return (w > DEPTH) ? DEPTH : int'(w);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [13:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [13:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      bus_rd(14'h3FC, s);
      if (!s[0]) break;
    end
  endtask

  // Memory model: one read at a time, fixed latency, checks address order (R4).
  initial begin
    int lat = 0;
    bit pend = 0;
    logic [31:0] paddr = '0;
    forever begin
      @(negedge clk);
      if (mem_rd_valid) mem_rd_valid = 1'b0;
      if (pend) begin
        if (lat == 0) begin
          mem_rd_valid = 1'b1; mem_rd_data = pat(paddr); pend = 0;
        end else lat--;
      end
      if (mem_rd_req) begin
        check(mem_rd_addr == next_addr, "R4 read address", mem_rd_addr, next_addr);
        paddr = mem_rd_addr; next_addr = next_addr + 4;
        pend = 1; lat = MEM_LAT - 1; reads++;
      end
    end
  end

  // Core model: fixed latency done; checks fetch completed before start (R7).
  initial begin
    int cnt = 0;
    bit cpend = 0;
    forever begin
      @(negedge clk);
      if (core_done) core_done = 1'b0;
      if (cpend) begin
        if (cnt == 0) begin core_done = 1'b1; cpend = 0; end else cnt--;
      end
      if (core_start) begin
        check(reads == exp_words_now, "R7 start after fetch", reads, exp_words_now);
        starts++; cpend = 1; cnt = CORE_LAT - 1;
      end
    end
  end

  // Runs one job and checks reads, starts, status and irq.
  task automatic run_job(input logic [31:0] cmd, input logic [31:0] base,
                         input logic [31:0] len, input logic [1:0] trig,
                         input bit mask, input bit verify_ram);
    bit fetch;
    int w;
    logic [31:0] r;
    fetch = trig[1] && (cmd[5:4] == 2'b11) && !cmd[8];
    w = fetch ? exp_words(len) : 0;
    bus_wr(14'h048, 32'h100);
    if (fetch && w < DEPTH) bus_wr(14'h2000 + 14'(w * 4), 32'hC0DE_0000 + 32'(w));
    bus_wr(14'h04C, base);
    bus_wr(14'h050, len);
    bus_wr(14'h3F8, {30'd0, mask, 1'b0});
    bus_wr(14'h048, cmd);
    reads = 0; starts = 0; exp_words_now = w;
    next_addr = {base[31:2], 2'b00};
    bus_wr(14'h000, {30'd0, trig});
    wait_idle();
    repeat (2) @(negedge clk);
    check(reads == w, fetch ? "R5 word count" : "R6 no fetch", reads, w);
    check(starts == (trig[0] ? 1 : 0), "R7 start count", starts, trig[0]);
    bus_rd(14'h3FC, r);
    check(r[1] == trig[0], "R8 done flag", r, {30'd0, trig[0], 1'b0});
    #1 check(irq == (trig[0] && mask), "R9 irq", irq, trig[0] && mask);
    bus_rd(14'h000, r);
    check(r[1:0] == trig, "R11 trigger readback", r, trig);
    if (verify_ram && fetch) begin
      bus_wr(14'h048, 32'h100);
      for (int i = 0; i < w; i++) begin
        bus_rd(14'h2000 + 14'(i * 4), r);
        check(r == pat({base[31:2], 2'b00} + 32'(i * 4)), "R4 stored word", r,
              pat({base[31:2], 2'b00} + 32'(i * 4)));
      end
      if (w < DEPTH) begin
        bus_rd(14'h2000 + 14'(w * 4), r);
        check(r == 32'hC0DE_0000 + 32'(w), "R5 word past count untouched", r,
              32'hC0DE_0000 + 32'(w));
      end
    end
    bus_wr(14'h3FC, 32'h2);
    bus_rd(14'h3FC, r);
    check(r[1] == 1'b0, "R8 cleared by write one", r, 0);
    #1 check(irq == 1'b0, "R9 irq low after clear", irq, 0);
    bus_wr(14'h000, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_rd(14'h000, r); check(r == 0, "R1 trigger reset", r, 0);
    bus_rd(14'h048, r); check(r == 32'h100, "R1 command reset", r, 32'h100);
    bus_rd(14'h3F8, r); check(r == 0, "R1 mask reset", r, 0);
    bus_rd(14'h3FC, r); check(r == 0, "R1 status reset", r, 0);
    check(irq == 0, "R1 irq reset", irq, 0);

    // R2 readback
    bus_wr(14'h04C, 32'hDEAD_BEEF); bus_rd(14'h04C, r);
    check(r == 32'hDEAD_BEEF, "R2 base", r, 32'hDEAD_BEEF);
    bus_wr(14'h050, 32'h0000_1800); bus_rd(14'h050, r);
    check(r == 32'h1800, "R2 length", r, 32'h1800);
    bus_wr(14'h058, 32'h0011_1000); bus_rd(14'h058, r);
    check(r == 32'h0011_1000, "R2 key length", r, 32'h0011_1000);
    check(core_exp_bits == 16'h0011, "R2 exponent bits", core_exp_bits, 16'h0011);
    check(core_mod_bits == 16'h1000, "R2 modulus bits", core_mod_bits, 16'h1000);
    bus_wr(14'h3F8, 32'hFFFF_FFFF); bus_rd(14'h3F8, r);
    check(r == 32'h2, "R2 mask bit 1 only", r, 32'h2);

    // R3 SRAM ownership
    bus_wr(14'h2010, 32'h1234_5678); bus_rd(14'h2010, r);
    check(r == 32'h1234_5678, "R3 cpu owns read", r, 32'h1234_5678);
    bus_wr(14'h048, 32'h030);
    bus_rd(14'h2010, r); check(r == 0, "R3 engine owns reads zero", r, 0);
    bus_wr(14'h2010, 32'hFFFF_0000);
    bus_wr(14'h048, 32'h100); bus_rd(14'h2010, r);
    check(r == 32'h1234_5678, "R3 write ignored while engine owns", r, 32'h1234_5678);

    // Directed jobs
    run_job(32'h030, 32'h8000_0003, 32'd13, 2'b11, 1'b1, 1'b1); // R4 unaligned base, round-up
    run_job(32'h030, 32'h0000_1000, 32'd0, 2'b11, 1'b1, 1'b0);  // R5 zero length
    run_job(32'h130, 32'h0000_2000, 32'd64, 2'b11, 1'b1, 1'b0); // R6 cpu owns
    run_job(32'h010, 32'h0000_2000, 32'd64, 2'b10, 1'b0, 1'b0); // R6 wrong mode
    run_job(32'h030, 32'h0010_0000, 32'h1FFF, 2'b11, 1'b1, 1'b1); // R5 limit at depth

    // R10 trigger while busy ignored
    begin
      reads = 0; starts = 0; exp_words_now = 0;
      bus_wr(14'h048, 32'h030);
      bus_wr(14'h000, 32'h1);
      bus_rd(14'h3FC, r); check(r[0] == 1'b1, "R10 busy while running", r, 1);
      bus_wr(14'h000, 32'h3);
      bus_wr(14'h000, 32'h0);
      bus_rd(14'h000, r); check(r == 32'h1, "R10 trigger frozen while busy", r, 1);
      wait_idle();
      repeat (2) @(negedge clk);
      check(reads == 0, "R10 no reads from ignored trigger", reads, 0);
      check(starts == 1, "R10 single start", starts, 1);
      bus_wr(14'h3FC, 32'h0);
      bus_rd(14'h3FC, r); check(r[1] == 1'b1, "R8 write zero keeps flag", r, 2);
      bus_wr(14'h000, 32'h0);
      bus_rd(14'h000, r); check(r == 0, "R11 write zero clears trigger", r, 0);
      bus_wr(14'h3FC, 32'h2);
    end

    // Constrained random jobs
    for (int k = 0; k < 24; k++) begin
      logic [31:0] cmd, base, len;
      logic [1:0] tr;
      bit m;
      cmd  = ($urandom % 4 != 0) ? 32'h030 : (($urandom % 2) ? 32'h130 : 32'h020);
      base = $urandom;
      len  = $urandom % 200;
      tr   = 2'(($urandom % 3) + 1);
      m    = 1'($urandom % 2);
      run_job(cmd, base, len, tr, m, 1'b1);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule